// File: doc/BRIEF.md
# Open-Row Request Arbiter with Burst Aging

This block sits between a set of memory masters and the command sequencer of a DRAM controller. Every master presents at most one request at a time, naming a bank, a row and a length in bursts. Each burst is one 32-byte transfer. In every cycle in which the sequencer can accept work, the arbiter picks one request and presents it on the grant output. In the same cycle it pulses the grant line of the chosen master.

The normal policy favours throughput. A request whose row is already open in its bank goes ahead of any request that would need an activate, whatever the fixed priorities of the masters. With that policy alone, a low-priority master that streams to an open row can shut everyone else out. An 8-bit threshold register bounds this. A counter adds up the bursts granted since the longest-waiting request was last served. Once the counter reaches the threshold, the longest-waiting request is granted next. The threshold resets to 0xFF, which turns aging off. A value near 0x20 is a typical compromise between a fast streamer and latency-sensitive masters.

Top module: `open_bank_arbiter`

## Requirements
- R1: After reset every bank is closed, so the first request to any bank is granted with `gnt_hit` low. With no request pending, `gnt_valid` is low.
- R2: A grant is issued only in a cycle with `seq_ready` high. `req_grant` is one-hot or zero and goes only to a master whose `req_valid` is high. `gnt_master`, `gnt_bank`, `gnt_row` and `gnt_len` carry that master's request. `gnt_valid` is high when `seq_ready` is high and any request is pending.
- R3: When aging is not promoting, a pending request that hits an open row is granted before every miss, regardless of master priority.
- R4: Within the same class (all hits, or all misses) the higher fixed master priority wins, and equal priorities go to the lower master index. The default priorities are 0, 2, 2 and 1 for masters 0 to 3.
- R5: Each bank holds one open row. Every grant opens the granted row in the granted bank and replaces the row held there before. `gnt_hit` is high only when the bank is open and the request's row equals its open row.
- R6: A write on the config port loads `cfg_wdata` into the threshold on the next clock edge. The threshold resets to 0xFF. At 0xFF no promotion ever happens, so a saturating row-hit streamer can hold off a missing request indefinitely.
- R7: When aging is enabled and the burst counter is at or above the threshold, the longest-waiting pending request is granted and `gnt_aged` is high. Against a single-burst row-hit streamer, a competing request is granted within threshold+1 grants.
- R8: The burst counter clears when the longest-waiting request is granted. Any other grant adds that grant's `req_len` to the counter, saturating at 255.
- R9: Waiting time counts the cycles since a request was raised. Among requests that have waited equally long, the higher priority and then the lower index counts as oldest. A request raised earlier is promoted ahead of a higher-priority one raised later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_wdata | input | 8 | Threshold value to write |
| req_valid | input | 4 | Per-master request pending |
| req_bank | input | 8 | Per-master bank, 2 bits per master |
| req_row | input | 48 | Per-master row, 12 bits per master |
| req_len | input | 16 | Per-master burst count, 4 bits per master |
| req_grant | output | 4 | Per-master grant, one-hot, valid in the accepting cycle |
| seq_ready | input | 1 | Sequencer accepts a grant this cycle |
| gnt_valid | output | 1 | A grant is presented this cycle |
| gnt_master | output | 2 | Index of the granted master |
| gnt_bank | output | 2 | Bank of the granted request |
| gnt_row | output | 12 | Row of the granted request |
| gnt_len | output | 16 | Burst count of the granted request, 4 bits used |
| gnt_hit | output | 1 | Granted request hits the open row |
| gnt_aged | output | 1 | Grant was forced by aging |

## Verification
The hardest state to reach from the ports is the promotion point. It needs a streamer that keeps re-requesting an open row in every cycle, a competitor waiting behind it, and the burst counter climbing through exactly the threshold. Directed sequences first open the row with a lone streamer grant, which clears the counter. They then raise the competitor and count grants up to the promotion. This is done with single-burst and with two-burst streams, and with the threshold at its reset value to show that the competitor is starved. Random traffic over few rows and banks, with random sequencer stalls and threshold rewrites, then mixes hits, misses and promotions against a cycle model kept in the bench.

// File: rtl/oba_pkg.sv
package oba_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_AGED = 2'd1,
    SEL_HIT  = 2'd2,
    SEL_BEST = 2'd3
  } sel_src_e;
endpackage

// File: rtl/oba_row_table.sv
module oba_row_table #(
  parameter int N_MST  = 4,
  parameter int N_BANK = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_MST*BANK_W-1:0]   req_bank,
  input  logic [N_MST*ROW_W-1:0]    req_row,
  input  logic                      upd_en,
  input  logic [BANK_W-1:0]         upd_bank,
  input  logic [ROW_W-1:0]          upd_row,
  output logic [N_MST-1:0]          hit
);
  logic [N_BANK-1:0] open_q;
  logic [N_BANK-1:0] open_d;
  logic [N_BANK-1:0] ld;
  logic [ROW_W-1:0]  row_q [N_BANK];
  logic [ROW_W-1:0]  row_d [N_BANK];

  always_comb begin
    for (int b = 0; b < N_BANK; b++) begin
      ld[b]     = upd_en && (upd_bank == BANK_W'(b));
      open_d[b] = ld[b] ? 1'b1 : open_q[b];
      row_d[b]  = ld[b] ? upd_row : row_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < N_BANK; b++) row_q[b] <= '0;
    end else begin
      for (int b = 0; b < N_BANK; b++) begin
        if (ld[b]) begin
          open_q[b] <= open_d[b];
          row_q[b]  <= row_d[b];
        end
      end
    end
  end

  genvar gm;
  generate
    for (gm = 0; gm < N_MST; gm++) begin : g_hit
      logic [BANK_W-1:0] bsel;
      logic [ROW_W-1:0]  rsel;
      assign bsel    = req_bank[gm*BANK_W +: BANK_W];
      assign rsel    = req_row[gm*ROW_W +: ROW_W];
      assign hit[gm] = open_q[bsel] && (row_q[bsel] == rsel);
    end
  endgenerate
endmodule

// File: rtl/oba_age_track.sv
module oba_age_track #(
  parameter int                        N_MST    = 4,
  parameter int                        AGE_W    = 10,
  parameter int                        PRIO_W   = 2,
  parameter logic [N_MST*PRIO_W-1:0]   MST_PRIO = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MST-1:0]  req_valid,
  input  logic [N_MST-1:0]  grant,
  output logic [N_MST-1:0]  oldest_oh
);
  localparam int MST_W = (N_MST > 1) ? $clog2(N_MST) : 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0]  age_q [N_MST];
  logic [AGE_W-1:0]  age_d [N_MST];
  logic [N_MST-1:0]  age_en;
  logic [PRIO_W-1:0] prio_a [N_MST];
  logic [MST_W-1:0]  best;
  logic              found;

  always_comb begin
    for (int m = 0; m < N_MST; m++) begin
      prio_a[m] = MST_PRIO[m*PRIO_W +: PRIO_W];
      age_en[m] = req_valid[m] || (age_q[m] != '0);
      if (!req_valid[m] || grant[m])  age_d[m] = '0;
      else if (age_q[m] == AGE_MAX)   age_d[m] = age_q[m];
      else                            age_d[m] = age_q[m] + AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < N_MST; m++) age_q[m] <= '0;
    end else begin
      for (int m = 0; m < N_MST; m++) begin
        if (age_en[m]) age_q[m] <= age_d[m];
      end
    end
  end

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int m = 0; m < N_MST; m++) begin
      if (req_valid[m]) begin
        if (!found || (age_q[m] > age_q[best]) ||
            ((age_q[m] == age_q[best]) && (prio_a[m] > prio_a[best]))) begin
          best  = MST_W'(m);
          found = 1'b1;
        end
      end
    end
    oldest_oh = '0;
    if (found) oldest_oh[best] = 1'b1;
  end
endmodule

// File: rtl/oba_pick.sv
module oba_pick #(
  parameter int                        N_MST    = 4,
  parameter int                        PRIO_W   = 2,
  parameter logic [N_MST*PRIO_W-1:0]   MST_PRIO = '0
) (
  input  logic [N_MST-1:0] cand,
  output logic [N_MST-1:0] win_oh
);
  localparam int MST_W = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic [PRIO_W-1:0] prio_a [N_MST];
  logic [MST_W-1:0]  best;
  logic              found;

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int m = 0; m < N_MST; m++) begin
      prio_a[m] = MST_PRIO[m*PRIO_W +: PRIO_W];
    end
    for (int m = 0; m < N_MST; m++) begin
      if (cand[m] && (!found || (prio_a[m] > prio_a[best]))) begin
        best  = MST_W'(m);
        found = 1'b1;
      end
    end
    win_oh = '0;
    if (found) win_oh[best] = 1'b1;
  end
endmodule

// File: rtl/oba_burst_age.sv
module oba_burst_age #(
  parameter int THR_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [THR_W-1:0] cfg_wdata,
  input  logic             fire,
  input  logic [LEN_W-1:0] fire_len,
  input  logic             fire_oldest,
  output logic             promote,
  output logic [THR_W-1:0] thr,
  output logic [THR_W-1:0] cnt
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0] thr_q, cnt_q, cnt_d;
  logic [THR_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + (THR_W+1)'(fire_len);
    cnt_d = cnt_q;
    if (fire) begin
      if (fire_oldest)                   cnt_d = '0;
      else if (sum > {1'b0, CNT_MAX})    cnt_d = CNT_MAX;
      else                               cnt_d = sum[THR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '1;
    else if (cfg_we) thr_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (fire) cnt_q <= cnt_d;
  end

  assign promote = (thr_q != CNT_MAX) && (cnt_q >= thr_q);
  assign thr     = thr_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/open_bank_arbiter.sv
module open_bank_arbiter #(
  parameter int                        N_MST    = 4,
  parameter int                        N_BANK   = 4,
  parameter int                        ROW_W    = 12,
  parameter int                        LEN_W    = 4,
  parameter int                        PRIO_W   = 2,
  parameter int                        AGE_W    = 10,
  parameter int                        THR_W    = 8,
  parameter logic [N_MST*PRIO_W-1:0]   MST_PRIO = {2'd1, 2'd2, 2'd2, 2'd0},
  localparam int                       BANK_W   = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int                       MST_W    = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [THR_W-1:0]          cfg_wdata,
  input  logic [N_MST-1:0]          req_valid,
  input  logic [N_MST*BANK_W-1:0]   req_bank,
  input  logic [N_MST*ROW_W-1:0]    req_row,
  input  logic [N_MST*LEN_W-1:0]    req_len,
  output logic [N_MST-1:0]          req_grant,
  input  logic                      seq_ready,
  output logic                      gnt_valid,
  output logic [MST_W-1:0]          gnt_master,
  output logic [BANK_W-1:0]         gnt_bank,
  output logic [ROW_W-1:0]          gnt_row,
  output logic [N_MST*LEN_W-1:0]    gnt_len,
  output logic                      gnt_hit,
  output logic                      gnt_aged
);
  import oba_pkg::*;

  logic [N_MST-1:0] hit_vec, hit_cand, hit_win, all_win, oldest_oh, win_oh;
  logic [MST_W-1:0] win_idx;
  logic             promote, fire, fire_oldest;
  logic [THR_W-1:0] thr_val, cnt_val;
  sel_src_e         sel_src;

  oba_row_table #(.N_MST(N_MST), .N_BANK(N_BANK), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .req_bank(req_bank), .req_row(req_row),
    .upd_en(fire), .upd_bank(gnt_bank), .upd_row(gnt_row), .hit(hit_vec));

  oba_age_track #(.N_MST(N_MST), .AGE_W(AGE_W), .PRIO_W(PRIO_W), .MST_PRIO(MST_PRIO)) u_age (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(req_grant), .oldest_oh(oldest_oh));

  oba_burst_age #(.THR_W(THR_W), .LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fire(fire), .fire_len(gnt_len[LEN_W-1:0]), .fire_oldest(fire_oldest),
    .promote(promote), .thr(thr_val), .cnt(cnt_val));

  assign hit_cand = req_valid & hit_vec;

  oba_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .MST_PRIO(MST_PRIO)) u_pick_hit (
    .cand(hit_cand), .win_oh(hit_win));
  oba_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .MST_PRIO(MST_PRIO)) u_pick_all (
    .cand(req_valid), .win_oh(all_win));

  always_comb begin
    sel_src = SEL_IDLE;
    win_oh  = '0;
    if (|req_valid) begin
      if (promote) begin
        sel_src = SEL_AGED;
        win_oh  = oldest_oh;
      end else if (|hit_cand) begin
        sel_src = SEL_HIT;
        win_oh  = hit_win;
      end else begin
        sel_src = SEL_BEST;
        win_oh  = all_win;
      end
    end
  end

  always_comb begin
    win_idx = '0;
    for (int m = 0; m < N_MST; m++) begin
      if (win_oh[m]) win_idx = MST_W'(m);
    end
  end

  assign req_grant   = win_oh & {N_MST{seq_ready}};
  assign fire        = seq_ready && (sel_src != SEL_IDLE);
  assign fire_oldest = |(req_grant & oldest_oh);
  assign gnt_valid   = fire;
  assign gnt_master  = win_idx;
  assign gnt_bank    = req_bank[win_idx*BANK_W +: BANK_W];
  assign gnt_row     = req_row[win_idx*ROW_W +: ROW_W];
  assign gnt_len     = {{(N_MST-1)*LEN_W{1'b0}}, req_len[win_idx*LEN_W +: LEN_W]};
  assign gnt_hit     = |(win_oh & hit_vec);
  assign gnt_aged    = seq_ready && (sel_src == SEL_AGED);
endmodule

// File: rtl/oba_checker.sv
module oba_checker #(
  parameter int N_MST = 4,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req_valid,
  input logic [N_MST-1:0] req_grant,
  input logic [N_MST-1:0] hit_vec,
  input logic             seq_ready,
  input logic             gnt_valid,
  input logic             gnt_hit,
  input logic             gnt_aged,
  input logic             cfg_we,
  input logic [THR_W-1:0] cfg_wdata,
  input logic [THR_W-1:0] thr,
  input logic [THR_W-1:0] cnt
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant)); // R2
  AST_GRANT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0); // R2
  AST_NO_READY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ready |-> (req_grant == '0)); // R2
  AST_HIT_PREFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_aged && ((req_valid & hit_vec) != '0)) |-> gnt_hit); // R3
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (thr == $past(cfg_wdata))); // R6
  AST_DISABLED_NO_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '1) |-> !gnt_aged); // R6
  AST_CNT_CLEAR_ON_AGED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_aged) |=> (cnt == '0)); // R8
endmodule

bind open_bank_arbiter oba_checker #(.N_MST(N_MST), .THR_W(THR_W)) u_oba_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
  .hit_vec(hit_vec), .seq_ready(seq_ready), .gnt_valid(gnt_valid), .gnt_hit(gnt_hit),
  .gnt_aged(gnt_aged), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .thr(thr_val), .cnt(cnt_val));

// File: tb/test_open_bank_arbiter.sv
module test_open_bank_arbiter;
  localparam int M = 4;
  localparam int BW = 2;
  localparam int RW = 12;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_d = 8'h00;
  logic [M-1:0] v = '0;
  logic [BW-1:0] bk [M];
  logic [RW-1:0] rw [M];
  logic [LW-1:0] ln [M];
  logic rdy = 1'b1;

  logic [M*BW-1:0] req_bank;
  logic [M*RW-1:0] req_row;
  logic [M*LW-1:0] req_len;
  logic [M-1:0] req_grant;
  logic gnt_valid, gnt_hit, gnt_aged;
  logic [1:0] gnt_master, gnt_bank;
  logic [RW-1:0] gnt_row;
  logic [M*LW-1:0] gnt_len;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < M; i++) begin
      req_bank[i*BW +: BW] = bk[i];
      req_row[i*RW +: RW]  = rw[i];
      req_len[i*LW +: LW]  = ln[i];
    end
  end

  open_bank_arbiter i_open_bank_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_d),
    .req_valid(v), .req_bank(req_bank), .req_row(req_row), .req_len(req_len),
    .req_grant(req_grant), .seq_ready(rdy), .gnt_valid(gnt_valid),
    .gnt_master(gnt_master), .gnt_bank(gnt_bank), .gnt_row(gnt_row),
    .gnt_len(gnt_len), .gnt_hit(gnt_hit), .gnt_aged(gnt_aged));

  int n_chk = 0;
  int n_bad = 0;
  bit m_open [4];
  int m_row [4];
  int m_age [M];
  int m_cnt, m_thr;
  int last_win;
  logic [M-1:0] obs_grant;
  logic obs_valid, obs_hit, obs_aged;
  int obs_master;

  function automatic int prio(int i);
    case (i)
      0: return 0;
      1: return 2;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic bit f_hit(int i);
    return m_open[bk[i]] && (m_row[bk[i]] == int'(rw[i]));
  endfunction

  function automatic int f_best(logic [M-1:0] mask);
    int b = -1;
    for (int i = 0; i < M; i++)
      if (mask[i] && (b < 0 || prio(i) > prio(b))) b = i;
    return b;
  endfunction

  function automatic int f_oldest();
    int b = -1;
    for (int i = 0; i < M; i++)
      if (v[i] && (b < 0 || m_age[i] > m_age[b] ||
                   (m_age[i] == m_age[b] && prio(i) > prio(b)))) b = i;
    return b;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    int ew, old;
    bit ea, eh, ok;
    logic [M-1:0] hm, eg;
    #2;
    old = f_oldest();
    ew = -1; ea = 0; eh = 0; hm = '0;
    if (rdy && v != '0) begin
      if (m_thr != 255 && m_cnt >= m_thr) begin
        ew = old; ea = 1;
      end else begin
        for (int i = 0; i < M; i++) if (v[i] && f_hit(i)) hm[i] = 1'b1;
        ew = (hm != '0) ? f_best(hm) : f_best(v);
      end
      eh = f_hit(ew);
    end
    eg = (ew >= 0) ? (M'(1) << ew) : '0;
    ok = (req_grant == eg) && (gnt_valid == (ew >= 0));
    if (ew >= 0)
      ok = ok && (int'(gnt_master) == ew) && (gnt_bank == bk[ew]) && (gnt_row == rw[ew]) &&
           (gnt_len[LW-1:0] == ln[ew]) && (gnt_hit == eh) && (gnt_aged == ea);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: grant=%b/%b master=%0d/%0d hit=%b/%b aged=%b/%b (actual/expected)",
               tag, req_grant, eg, gnt_master, ew, gnt_hit, eh, gnt_aged, ea);
    end
    obs_grant = req_grant; obs_valid = gnt_valid; obs_hit = gnt_hit;
    obs_aged = gnt_aged; obs_master = int'(gnt_master);
    last_win = ew;
    @(posedge clk);
    for (int i = 0; i < M; i++) begin
      if (!v[i] || i == ew) m_age[i] = 0;
      else if (m_age[i] < 1023) m_age[i]++;
    end
    if (ew >= 0) begin
      if (ew == old) m_cnt = 0;
      else m_cnt = (m_cnt + int'(ln[ew]) > 255) ? 255 : m_cnt + int'(ln[ew]);
      m_open[bk[ew]] = 1'b1;
      m_row[bk[ew]] = int'(rw[ew]);
    end
    if (cfg_we) m_thr = int'(cfg_d);
    @(negedge clk);
  endtask

  task automatic set_req(int i, int b, int r, int l);
    v[i] = 1'b1; bk[i] = BW'(b); rw[i] = RW'(r); ln[i] = LW'(l);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; v = '0; rdy = 1'b1; cfg_we = 1'b0;
    for (int i = 0; i < M; i++) begin bk[i] = '0; rw[i] = '0; ln[i] = 4'd1; m_age[i] = 0; end
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
    m_cnt = 0; m_thr = 255; last_win = -1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_thr(int t);
    cfg_we = 1'b1; cfg_d = 8'(t);
    step("R6 cfg write");
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    bit got;
    void'($urandom(32'd20241));
    do_reset();

    // R1: idle after reset, first access is a miss
    step("R1 idle");
    chk(obs_valid == 1'b0, "R1 idle gnt_valid", obs_valid, 0);
    set_req(3, 0, 5, 1);
    step("R1 first");
    chk(obs_grant[3] && !obs_hit, "R1 first access miss", obs_hit, 0);
    v[3] = 1'b0;

    // R2: no grant while sequencer stalls
    rdy = 1'b0; set_req(0, 1, 1, 1);
    step("R2 stall");
    chk(obs_grant == '0 && !obs_valid, "R2 stall no grant", obs_grant, 0);
    rdy = 1'b1; v[0] = 1'b0;

    // R6: default threshold starves a miss behind a row-hit streamer
    do_reset();
    set_req(0, 1, 7, 1);
    step("R6 open");
    set_req(3, 1, 9, 1);
    got = 0;
    repeat (300) begin
      step("R6 stream");
      if (obs_grant[3]) got = 1;
    end
    chk(!got, "R6 threshold 0xFF no promotion", got, 0);
    write_thr(8'h20);
    step("R6 after write");
    chk(obs_grant[3] && obs_aged, "R6 new threshold takes effect", obs_master, 3);
    v[3] = 1'b0;

    // R7: bounded wait of threshold+1 single-burst grants
    do_reset();
    write_thr(8'h20);
    set_req(0, 1, 7, 1);
    step("R7 open");
    set_req(3, 1, 9, 1);
    n = 0;
    do begin step("R7 stream"); n++; end while (!obs_grant[3] && n < 100);
    chk(n == 33, "R7 competitor granted at grant threshold+1", n, 33);
    chk(obs_aged, "R7 promoted grant flagged aged", obs_aged, 1);
    v[3] = 1'b0;

    // R8: counter advances by burst length
    do_reset();
    write_thr(4);
    set_req(0, 1, 7, 2);
    step("R8 open");
    set_req(3, 2, 9, 1);
    n = 0;
    do begin step("R8 stream"); n++; end while (!obs_grant[3] && n < 50);
    chk(n == 3, "R8 two-burst stream promotes on third grant", n, 3);
    v[3] = 1'b0;

    // R3: hit beats higher-priority miss
    do_reset();
    set_req(0, 2, 3, 1);
    step("R3 open");
    set_req(0, 2, 3, 1); set_req(3, 0, 1, 1);
    step("R3 race");
    chk(obs_master == 0 && obs_hit, "R3 row hit wins over priority", obs_master, 0);
    v[0] = 1'b0;
    step("R3 miss served");
    chk(obs_master == 3 && !obs_hit, "R3 miss served after", obs_master, 3);
    v[3] = 1'b0;

    // R5: row replacement in a bank
    set_req(2, 2, 4, 1);
    step("R5 new row");
    chk(obs_master == 2 && !obs_hit, "R5 other row in open bank misses", obs_hit, 0);
    v[2] = 1'b0;
    set_req(1, 2, 3, 1);
    step("R5 old row");
    chk(obs_master == 1 && !obs_hit, "R5 replaced row now misses", obs_hit, 0);
    v[1] = 1'b0;
    set_req(2, 2, 3, 1);
    step("R5 reopened");
    chk(obs_master == 2 && obs_hit, "R5 reopened row hits", obs_hit, 1);
    v[2] = 1'b0;

    // R4: priority and index tie break among misses
    do_reset();
    set_req(1, 0, 1, 1); set_req(2, 1, 1, 1); set_req(3, 2, 1, 1);
    step("R4 a");
    chk(obs_master == 1, "R4 equal priority lower index", obs_master, 1);
    v[1] = 1'b0;
    step("R4 b");
    chk(obs_master == 2, "R4 priority 2 before 1", obs_master, 2);
    v[2] = 1'b0;
    step("R4 c");
    v[3] = 1'b0;

    // R9: oldest request wins when promoted
    do_reset();
    write_thr(0);
    rdy = 1'b0;
    set_req(3, 0, 1, 1);
    step("R9 first");
    set_req(1, 1, 1, 1);
    step("R9 second");
    rdy = 1'b1;
    step("R9 grant");
    chk(obs_master == 3 && obs_aged, "R9 earlier request promoted first", obs_master, 3);
    v[3] = 1'b0;
    step("R9 next");
    chk(obs_master == 1, "R9 later request next", obs_master, 1);
    v[1] = 1'b0;

    // random traffic: R2 R3 R4 R5 R7 R8
    do_reset();
    repeat (4000) begin
      for (int i = 0; i < M; i++) begin
        if (v[i] && last_win == i) begin
          v[i] = 1'($urandom % 2);
          if (v[i]) set_req(i, $urandom % 4, $urandom % 3, 1 + $urandom % 3);
        end else if (!v[i] && ($urandom % 3 == 0)) begin
          set_req(i, $urandom % 4, $urandom % 3, 1 + $urandom % 3);
        end
      end
      rdy = ($urandom % 4) != 0;
      if ($urandom % 60 == 0) begin
        cfg_we = 1'b1;
        case ($urandom % 5)
          0: cfg_d = 8'd0;
          1: cfg_d = 8'd2;
          2: cfg_d = 8'd5;
          3: cfg_d = 8'h20;
          default: cfg_d = 8'hFF;
        endcase
      end
      step("R2 R3 R4 R5 R7 R8 random");
      cfg_we = 1'b0;
    end
    finish_run();
  end
endmodule